// File: doc/BRIEF.md
# Asynchronous NAND Bus Cycle Sequencer

This block runs single bus cycles on an asynchronous NAND flash interface: command latch, address latch, data write and data read. A request carries the cycle type, a byte, and three phase lengths counted in controller clock cycles: address setup, data setup and data hold. From these three counts the block places every edge of chip enable, the command and address latch enables, the write strobe and the read strobe. Chip enable gets one extra cycle at each end. A read first waits on the ready/busy line.

Reads support two capture points. In normal mode the byte is sampled on the clock edge where the read strobe returns high. In extended-data-out mode it is sampled a programmable number of clock edges later, which covers the longer data valid window of fast parts. Larger values cover extra board delay; 8 is a typical setting. The user side is a valid/ready request port with a one-cycle acknowledge that returns the read byte.

Top module: `nand_cycle_seq`

## Requirements
- R1: After reset the block is idle: chip enable, write strobe and read strobe are inactive (high), both latch enables, output enable and acknowledge are low, and `req_ready` is high.
- R2: For the write-type kinds (0 command, 1 address, 2 data write), the write strobe is low for exactly the data-setup count. The latch enable of the kind (CLE for 0, ALE for 1, neither for 2) rises address setup plus data setup cycles before the strobe rises and stays high for the data-hold count after it.
- R3: On write-type cycles, chip enable falls one cycle before the latch enable phase begins and rises one cycle after it ends.
- R4: With an address setup of zero, the write strobe falls in the cycle right after the one-cycle chip enable lead.
- R5: A data-setup or data-hold value of zero is treated as one.
- R6: The data output enable is high exactly from the start of address setup to the end of data hold on write-type cycles, and `nand_dq_o` carries the request byte there. It is never high on a read (kind 3).
- R7: A read keeps chip enable low and waits while `nand_rdy` is low. The read strobe falls address setup plus two cycles after the first clock edge that samples `nand_rdy` high.
- R8: On a read, the read strobe is low for the data-setup count, then high for the data-hold count before chip enable can be released.
- R9: In normal read mode (`req_edo` = 0), the returned byte is the bus value at the clock edge where the read strobe goes high.
- R10: In extended-data-out mode, the byte is captured `req_edo_delay` clock edges after that edge. Chip enable release and acknowledge wait for the capture when it lands after the hold phase.
- R11: `req_ready` is high only while idle. A request is taken when `req_valid` and `req_ready` are both high. `ack` is a one-cycle pulse in the first idle cycle after chip enable is released, with `rd_byte` valid for reads.
- R12: The write and read strobes are never low together. The read strobe stays high on write-type cycles and the write strobe stays high on reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_kind | input | 2 | 0 command, 1 address, 2 data write, 3 data read |
| req_byte | input | DATA_W | Byte driven on write-type cycles |
| req_addr_setup | input | PHASE_W | Address setup length in cycles (0 allowed) |
| req_data_setup | input | PHASE_W | Data setup / strobe low length (0 read as 1) |
| req_data_hold | input | PHASE_W | Data hold / strobe high length (0 read as 1) |
| req_edo | input | 1 | Extended-data-out read capture |
| req_edo_delay | input | DLY_W | Capture delay in clock edges for extended-data-out reads |
| ack | output | 1 | One-cycle completion pulse |
| rd_byte | output | DATA_W | Captured read byte |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_o | output | DATA_W | Data bus output value |
| nand_dq_oe | output | 1 | Data bus output enable |
| nand_dq_i | input | DATA_W | Data bus input value |
| nand_rdy | input | 1 | Ready/busy from the flash, high when ready |

## Verification
The bench builds the block with its defaults: 4-bit phase fields, an 8-bit bus and a 4-bit capture delay. It sweeps address setup 0 to 3 and data setup and hold 0 to 3 for all three write-type kinds, so the zero-setup skip and the zero-to-one clamp both come up in every combination. Reads sweep the same setup range with holds 1 to 3, ready arriving at once or three cycles late, and capture delays of 0, 1, 5 and 8. This covers both captures inside the hold phase and captures that stretch the release. The bench drives the bus with a value that steps every cycle, so the captured byte shows exactly which edge sampled it.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

    localparam int PHASE_W_DEF = 4;
    localparam int DATA_W_DEF  = 8;
    localparam int DLY_W_DEF   = 4;

    typedef enum logic [1:0] {
        CYC_CMD   = 2'd0,
        CYC_ADDR  = 2'd1,
        CYC_WRITE = 2'd2,
        CYC_READ  = 2'd3
    } cyc_kind_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_LEAD,
        PH_WAIT,
        PH_SETUP,
        PH_STROBE,
        PH_HOLD,
        PH_TAIL
    } phase_e;

    function automatic logic kind_drives_bus(cyc_kind_e k);
        return k != CYC_READ;
    endfunction

    function automatic logic phase_is_active(phase_e p);
        return (p == PH_SETUP) || (p == PH_STROBE) || (p == PH_HOLD);
    endfunction

endpackage

// File: rtl/nand_phase_timer.sv
module nand_phase_timer #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_len_m1,
    output logic             done
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_len_m1;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/nand_read_capture.sv
module nand_read_capture #(
    parameter int DATA_W = 8,
    parameter int DLY_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe_end,
    input  logic              edo,
    input  logic [DLY_W-1:0]  delay,
    input  logic [DATA_W-1:0] dq_i,
    output logic [DATA_W-1:0] rd_byte,
    output logic              busy
);
    logic             pending;
    logic [DLY_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 1'b0;
            cnt     <= '0;
            rd_byte <= '0;
        end else if (strobe_end) begin
            cnt <= delay;
            if (!edo || delay == '0) begin
                rd_byte <= dq_i;
                pending <= 1'b0;
            end else begin
                pending <= 1'b1;
            end
        end else if (pending) begin
            cnt <= cnt - 1'b1;
            if (cnt == DLY_W'(1)) begin
                rd_byte <= dq_i;
                pending <= 1'b0;
            end
        end
    end

    // busy low on the capturing edge lets the release coincide with capture
    assign busy = pending && (cnt != DLY_W'(1));

    // R10
    edo_count_down_chk: assert property (@(posedge clk) disable iff (rst)
        (pending && !strobe_end && cnt != DLY_W'(1)) |=> pending);
endmodule

// File: rtl/nand_strobe_decode.sv
module nand_strobe_decode
    import nand_seq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  phase_e            phase,
    input  cyc_kind_e         kind,
    input  logic [DATA_W-1:0] data,
    output logic              ce_n,
    output logic              cle,
    output logic              ale,
    output logic              we_n,
    output logic              re_n,
    output logic [DATA_W-1:0] dq_o,
    output logic              dq_oe
);
    logic drive;
    logic active;

    always_comb begin
        drive  = kind_drives_bus(kind);
        active = phase_is_active(phase);
        ce_n   = (phase == PH_IDLE);
        cle    = active && (kind == CYC_CMD);
        ale    = active && (kind == CYC_ADDR);
        we_n   = !(drive && phase == PH_STROBE);
        re_n   = !(!drive && phase == PH_STROBE);
        dq_oe  = drive && active;
        dq_o   = data;
    end
endmodule

// File: rtl/nand_cycle_seq.sv
module nand_cycle_seq
    import nand_seq_pkg::*;
#(
    parameter int PHASE_W = PHASE_W_DEF,
    parameter int DATA_W  = DATA_W_DEF,
    parameter int DLY_W   = DLY_W_DEF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [1:0]         req_kind,
    input  logic [DATA_W-1:0]  req_byte,
    input  logic [PHASE_W-1:0] req_addr_setup,
    input  logic [PHASE_W-1:0] req_data_setup,
    input  logic [PHASE_W-1:0] req_data_hold,
    input  logic               req_edo,
    input  logic [DLY_W-1:0]   req_edo_delay,
    output logic               ack,
    output logic [DATA_W-1:0]  rd_byte,
    output logic               nand_ce_n,
    output logic               nand_cle,
    output logic               nand_ale,
    output logic               nand_we_n,
    output logic               nand_re_n,
    output logic [DATA_W-1:0]  nand_dq_o,
    output logic               nand_dq_oe,
    input  logic [DATA_W-1:0]  nand_dq_i,
    input  logic               nand_rdy
);
    localparam int CNT_W = PHASE_W + 1;

    typedef struct packed {
        cyc_kind_e          kind;
        logic [DATA_W-1:0]  data;
        logic [PHASE_W-1:0] as_len;
        logic [PHASE_W-1:0] ds_len;
        logic [PHASE_W-1:0] dh_len;
        logic               edo;
        logic [DLY_W-1:0]   dly;
    } req_t;

    phase_e           ph, ph_nxt;
    req_t             cur;
    logic             tmr_load, tmr_done, strobe_end, cap_busy;
    logic [CNT_W-1:0] tmr_len;

    assign req_ready = (ph == PH_IDLE);

    always_comb begin
        ph_nxt     = ph;
        tmr_load   = 1'b0;
        tmr_len    = '0;
        strobe_end = 1'b0;
        case (ph)
            PH_IDLE:   if (req_valid)
                           ph_nxt = (cyc_kind_e'(req_kind) == CYC_READ) ? PH_WAIT : PH_LEAD;
            PH_LEAD: begin
                tmr_load = 1'b1;
                if (cur.as_len != '0) begin
                    ph_nxt  = PH_SETUP;
                    tmr_len = CNT_W'(cur.as_len) - 1'b1;
                end else begin
                    ph_nxt  = PH_STROBE;
                    tmr_len = CNT_W'(cur.ds_len) - 1'b1;
                end
            end
            PH_WAIT:   if (nand_rdy) begin
                           ph_nxt   = PH_SETUP;
                           tmr_load = 1'b1;
                           tmr_len  = CNT_W'(cur.as_len) + 1'b1;
                       end
            PH_SETUP:  if (tmr_done) begin
                           ph_nxt   = PH_STROBE;
                           tmr_load = 1'b1;
                           tmr_len  = CNT_W'(cur.ds_len) - 1'b1;
                       end
            PH_STROBE: if (tmr_done) begin
                           ph_nxt     = PH_HOLD;
                           tmr_load   = 1'b1;
                           tmr_len    = CNT_W'(cur.dh_len) - 1'b1;
                           strobe_end = (cur.kind == CYC_READ);
                       end
            PH_HOLD:   if (tmr_done) ph_nxt = PH_TAIL;
            PH_TAIL:   if (!cap_busy) ph_nxt = PH_IDLE;
            default:   ph_nxt = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph  <= PH_IDLE;
            cur <= '0;
            ack <= 1'b0;
        end else begin
            ph  <= ph_nxt;
            ack <= (ph == PH_TAIL) && (ph_nxt == PH_IDLE);
            if (ph == PH_IDLE && req_valid) begin
                cur.kind   <= cyc_kind_e'(req_kind);
                cur.data   <= req_byte;
                cur.as_len <= req_addr_setup;
                cur.ds_len <= (req_data_setup == '0) ? PHASE_W'(1) : req_data_setup;
                cur.dh_len <= (req_data_hold == '0) ? PHASE_W'(1) : req_data_hold;
                cur.edo    <= req_edo;
                cur.dly    <= req_edo_delay;
            end
        end
    end

    nand_phase_timer #(.CNT_W(CNT_W)) i_timer (
        .clk(clk), .rst(rst), .load(tmr_load), .load_len_m1(tmr_len), .done(tmr_done)
    );

    nand_read_capture #(.DATA_W(DATA_W), .DLY_W(DLY_W)) i_capture (
        .clk(clk), .rst(rst), .strobe_end(strobe_end), .edo(cur.edo),
        .delay(cur.dly), .dq_i(nand_dq_i), .rd_byte(rd_byte), .busy(cap_busy)
    );

    nand_strobe_decode #(.DATA_W(DATA_W)) i_decode (
        .phase(ph), .kind(cur.kind), .data(cur.data),
        .ce_n(nand_ce_n), .cle(nand_cle), .ale(nand_ale),
        .we_n(nand_we_n), .re_n(nand_re_n), .dq_o(nand_dq_o), .dq_oe(nand_dq_oe)
    );

    // R12
    strobes_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(!nand_we_n && !nand_re_n));

    // R3
    strobe_inside_ce_chk: assert property (@(posedge clk) disable iff (rst)
        (!nand_we_n || !nand_re_n) |-> !nand_ce_n);

    // R3
    ce_lead_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(nand_ce_n) |-> (!nand_cle && !nand_ale && nand_we_n));

    // R2
    latch_enables_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(nand_cle && nand_ale));

    // R6
    no_drive_on_read_chk: assert property (@(posedge clk) disable iff (rst)
        nand_dq_oe |-> nand_re_n);

    // R11
    ack_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack);

    // R11
    accept_leaves_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (!req_ready && !nand_ce_n));

    // R11
    ack_after_release_chk: assert property (@(posedge clk) disable iff (rst)
        ack |-> (nand_ce_n && req_ready));
endmodule

// File: tb/test_nand_cycle_seq.sv
module test_nand_cycle_seq;
    localparam int CLK_PERIOD = 10;
    localparam int PW = 4;
    localparam int DW = 8;
    localparam int LW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_kind = '0;
    logic [DW-1:0] req_byte = '0;
    logic [PW-1:0] req_addr_setup = '0, req_data_setup = '0, req_data_hold = '0;
    logic          req_edo = 1'b0;
    logic [LW-1:0] req_edo_delay = '0;
    logic          ack;
    logic [DW-1:0] rd_byte;
    logic          nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
    logic [DW-1:0] nand_dq_o;
    logic [DW-1:0] nand_dq_i = '0;
    logic          nand_rdy = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    nand_cycle_seq #(.PHASE_W(PW), .DATA_W(DW), .DLY_W(LW)) i_nand_cycle_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_byte(req_byte), .req_addr_setup(req_addr_setup),
        .req_data_setup(req_data_setup), .req_data_hold(req_data_hold),
        .req_edo(req_edo), .req_edo_delay(req_edo_delay), .ack(ack), .rd_byte(rd_byte),
        .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
        .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_dq_o(nand_dq_o),
        .nand_dq_oe(nand_dq_oe), .nand_dq_i(nand_dq_i), .nand_rdy(nand_rdy)
    );

    int n_checks = 0;
    int n_fail = 0;

    // per-cycle trace: [7]ce_n [6]cle [5]ale [4]we_n [3]re_n [2]oe [1]ack [0]ready
    logic [7:0]    tr   [0:63];
    logic [DW-1:0] tr_dq[0:63];

    int c_kind, c_as, c_ds, c_dh, c_ds_raw, c_dh_raw, c_s, c_d;
    bit c_edo;
    logic [DW-1:0] c_byte, c_base;

    task automatic check(bit ok, string tag, string what, int act, int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d (kind %0d as %0d ds %0d dh %0d edo %0d dly %0d)",
                     tag, what, act, expv, c_kind, c_as, c_ds_raw, c_dh_raw, c_edo, c_d);
        end
    endtask

    function automatic int ack_idx();
        int r1, tail;
        if (c_kind != 3) return c_as + c_ds + c_dh + 2;
        r1 = c_s + c_as + 2 + c_ds;
        tail = c_dh + 1;
        if (c_edo && c_d > tail) tail = c_d;
        return r1 + 1 + tail;
    endfunction

    function automatic logic [7:0] exp_vec(int i);
        logic ce_n, cle, ale, we_n, re_n, oe, ak, rdy;
        int a, so;
        bit act;
        a = ack_idx();
        ce_n = (i >= a); ak = (i == a); rdy = (i >= a);
        cle = 1'b0; ale = 1'b0; oe = 1'b0; we_n = 1'b1; re_n = 1'b1;
        if (c_kind != 3) begin
            act  = (i >= 1) && (i <= c_as + c_ds + c_dh);
            cle  = act && (c_kind == 0);
            ale  = act && (c_kind == 1);
            oe   = act;
            we_n = !((i >= c_as + 1) && (i <= c_as + c_ds));
        end else begin
            so   = c_s + c_as + 3;
            re_n = !((i >= so) && (i <= so + c_ds - 1));
        end
        return {ce_n, cle, ale, we_n, re_n, oe, ak, rdy};
    endfunction

    task automatic run_txn();
        int n;
        string names[8];
        string tags[8];
        string extra;
        logic [DW-1:0] exp_rd;
        names = '{"ack_ready", "ack", "oe", "re_n", "we_n", "ale", "cle", "ce_n"};
        if (c_kind != 3)
            tags = '{"R11", "R11", "R6", "R12", "R2", "R2", "R2", "R3"};
        else
            tags = '{"R11", "R10 R11", "R6", "R7 R8", "R12", "R12", "R12", "R8 R10"};
        extra = "";
        if (c_as == 0) extra = {extra, " R4"};
        if (c_ds_raw == 0 || c_dh_raw == 0) extra = {extra, " R5"};

        @(negedge clk);
        req_kind = 2'(c_kind); req_byte = c_byte;
        req_addr_setup = PW'(c_as); req_data_setup = PW'(c_ds_raw); req_data_hold = PW'(c_dh_raw);
        req_edo = c_edo; req_edo_delay = LW'(c_d);
        if (c_kind == 3) nand_rdy = 1'b0;
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        n = ack_idx() + 1;
        for (int i = 0; i <= n; i++) begin
            if (i > 0) @(negedge clk);
            tr[i]    = {nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe, ack, req_ready};
            tr_dq[i] = nand_dq_o;
            nand_dq_i = c_base + DW'(i);
            if (c_kind == 3 && i == c_s) nand_rdy = 1'b1;
        end
        for (int b = 0; b < 8; b++) begin
            int bad;
            logic av, ev;
            bad = -1; av = 1'b0; ev = 1'b0;
            for (int i = 0; i <= n; i++) begin
                logic [7:0] e;
                e = exp_vec(i);
                if (bad < 0 && tr[i][b] !== e[b]) begin
                    bad = i; av = tr[i][b]; ev = e[b];
                end
            end
            check(bad < 0, {tags[b], extra}, $sformatf("%s at cycle %0d", names[b], bad), int'(av), int'(ev));
        end
        if (c_kind != 3) begin
            check(tr_dq[c_as + 1] === c_byte, "R6", "dq_o during strobe",
                  int'(tr_dq[c_as + 1]), int'(c_byte));
        end else begin
            exp_rd = c_base + DW'(c_s + c_as + 2 + c_ds);
            if (c_edo) exp_rd = exp_rd + DW'(c_d);
            check(rd_byte === exp_rd, c_edo ? "R10" : "R9", "rd_byte", int'(rd_byte), int'(exp_rd));
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        c_kind = 0; c_as = 0; c_ds = 1; c_dh = 1; c_ds_raw = 1; c_dh_raw = 1; c_s = 0; c_d = 0; c_edo = 0;
        check({nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe, ack, req_ready} === 8'b1001_1001,
              "R1", "reset outputs",
              int'({nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe, ack, req_ready}),
              int'(8'b1001_1001));

        for (int k = 0; k < 3; k++)
            for (int a = 0; a < 4; a++)
                for (int s = 0; s < 4; s++)
                    for (int h = 0; h < 4; h++) begin
                        c_kind = k; c_as = a; c_ds_raw = s; c_dh_raw = h;
                        c_ds = (s == 0) ? 1 : s; c_dh = (h == 0) ? 1 : h;
                        c_s = 0; c_d = 0; c_edo = 0;
                        c_byte = DW'(k * 64 + a * 16 + s * 4 + h) ^ 8'h5A;
                        c_base = '0;
                        run_txn();
                    end

        for (int a = 0; a < 4; a++)
            for (int s = 1; s < 4; s++)
                for (int h = 1; h < 4; h++)
                    for (int w = 0; w < 2; w++)
                        for (int m = 0; m < 5; m++) begin
                            c_kind = 3; c_as = a; c_ds_raw = s; c_dh_raw = h;
                            c_ds = s; c_dh = h; c_s = w * 3;
                            c_edo = (m != 0);
                            case (m)
                                1: c_d = 0;
                                2: c_d = 1;
                                3: c_d = 5;
                                4: c_d = 8;
                                default: c_d = 3;
                            endcase
                            c_byte = 8'h00;
                            c_base = DW'(a * 37 + s * 11 + h * 5 + m * 3 + w);
                            run_txn();
                        end

        finish_run();
    end
endmodule